// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block handles the bookkeeping for a single DMA channel. The channel pairs one peripheral data register, which sits at a fixed address, with a memory region. It moves a programmed number of data items between them. Each item is one transaction, done in this order:

1. a bus read from the source side;
2. a bus write to the destination side;
3. a decrement of the remaining-item counter;
4. a one-cycle acknowledge pulse back to the requesting peripheral.

The engine holds a current address for each side. Both current addresses are loaded from base inputs when the channel is enabled. Each side has its own data size and its own post-increment enable, so either address can advance by 1, 2 or 4 bytes, or stay where it is.

The configuration inputs must be held stable while `ch_en` is high. A bus access is held until `bus_rdy` is seen high on a rising clock edge. Read data is taken in that same cycle.

The controller is a state machine with seven states:

- **IDLE**: goes to ARM when enabled, loading the base addresses and the item count.
- **ARM**: goes to DONE if the count is zero, otherwise to WAIT.
- **WAIT**: goes to READ on `per_req`.
- **READ**: goes to WRITE on `bus_rdy`.
- **WRITE**: goes to ACK on `bus_rdy`. The address step and the count decrement happen on this transition.
- **ACK**: goes to DONE if the count is now zero, otherwise back to WAIT.
- **DONE**: stays until `ch_en` falls.

Dropping `ch_en` returns the machine to IDLE from any state.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `bus_req`, `per_ack` and `xfer_done` are low and `remaining` is zero.
- R2: The first read of a transfer uses the base address of the source side. Sources are the peripheral when `cfg_dir`=0 and memory when `cfg_dir`=1.
- R3: A transaction starts only when `per_req` is high in WAIT. It runs in this order: a read (`bus_we`=0, `bus_size` = source size), then the next cycle after the read completes a write (`bus_we`=1, `bus_size` = destination size), then a `per_ack` that lasts exactly one cycle.
- R4: With `cfg_dir`=0, data moves from the peripheral address to the memory address. With `cfg_dir`=1, it moves from memory to the peripheral.
- R5: With a side's increment enable set, that side's address advances after each transaction by its size. Size code 00 steps by 1, 01 by 2, and 10 or 11 by 4.
- R6: With a side's increment enable clear, that side's address stays at its base for every transaction.
- R7: The value read is zero-extended from the source size. The bits above the destination size are cleared before the write. Data sits in the low bits of the 32-bit bus, and the byte mask is 0xFF for 00, 0xFFFF for 01, and all ones for 10 or 11.
- R8: `remaining` drops by one in the cycle `per_ack` is high. When it reaches zero, `xfer_done` goes high in the next cycle.
- R9: While `xfer_done` is high, requests are ignored: there is no bus access and no `per_ack` until `ch_en` has gone low and high again.
- R10: Enabling with `cfg_count`=0 raises `xfer_done` two cycles later without any bus access.
- R11: While `bus_req` is high and `bus_rdy` is low, the address, direction and size stay stable.
- R12: Lowering `ch_en` returns the channel to idle in the next cycle. `bus_req`, `per_ack` and `xfer_done` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable; a rise starts a transfer, low aborts |
| cfg_dir | input | 1 | 0 = peripheral to memory, 1 = memory to peripheral |
| cfg_per_base | input | ADDR_W | Peripheral base address |
| cfg_mem_base | input | ADDR_W | Memory base address |
| cfg_count | input | CNT_W | Number of items to move |
| cfg_per_size | input | 2 | Peripheral item size code |
| cfg_mem_size | input | 2 | Memory item size code |
| cfg_per_inc | input | 1 | Peripheral address post-increment enable |
| cfg_mem_inc | input | 1 | Memory address post-increment enable |
| per_req | input | 1 | Peripheral request |
| per_ack | output | 1 | One-cycle acknowledge after each store |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_size | output | 2 | Size code of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_rdy | input | 1 | Access completes on this cycle |
| xfer_done | output | 1 | Transfer complete |
| remaining | output | CNT_W | Items still to move |

## Verification
A wrong current-address register shows up on `bus_addr` at the very next read or write of the affected side. A wrong step size therefore appears by the second transaction. A counter that is off by one shows up on `remaining` in the first acknowledge cycle. It also shows up as an extra or missing transaction before `xfer_done`. A state machine that skips or reorders READ, WRITE and ACK is caught within one transaction, because every bus phase is checked for direction, size, address and data. An engine that keeps working after completion shows up as bus activity during the idle cycles the bench holds in DONE.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } item_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_ACK,
        ST_DONE
    } chan_state_e;

    // Lane mask for an item of the given size code.
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        unique case (item_size_e'(sz))
            SZ_BYTE: m = DATA_W'(32'h0000_00FF);
            SZ_HALF: m = DATA_W'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

    // Address step in bytes for an item of the given size code.
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        logic [2:0] s;
        unique case (item_size_e'(sz))
            SZ_BYTE: s = 3'd1;
            SZ_HALF: s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_addr_track.sv
module dma_addr_track
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic              inc_en,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] cur
);

    logic [ADDR_W-1:0] step_ext;

    assign step_ext = inc_en ? ADDR_W'(size_step(size)) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= base;
        end else if (advance) begin
            cur <= cur + step_ext;
        end
    end

endmodule

// File: rtl/dma_item_count.sv
module dma_item_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);

    assign is_zero = (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= init;
        end else if (dec && !is_zero) begin
            count <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
    import dma_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ch_en,
    input  logic per_req,
    input  logic bus_rdy,
    input  logic cnt_zero,
    output logic ld_cfg,
    output logic cap_data,
    output logic step_ptrs,
    output logic bus_req,
    output logic bus_we,
    output logic per_ack,
    output logic xfer_done
);

    chan_state_e state;
    chan_state_e nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        if (!ch_en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_ARM;
                ST_ARM:   nxt = cnt_zero ? ST_DONE : ST_WAIT;
                ST_WAIT:  nxt = per_req ? ST_READ : ST_WAIT;
                ST_READ:  nxt = bus_rdy ? ST_WRITE : ST_READ;
                ST_WRITE: nxt = bus_rdy ? ST_ACK : ST_WRITE;
                ST_ACK:   nxt = cnt_zero ? ST_DONE : ST_WAIT;
                ST_DONE:  nxt = ST_DONE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Outputs per state
    always_comb begin
        ld_cfg    = 1'b0;
        cap_data  = 1'b0;
        step_ptrs = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        per_ack   = 1'b0;
        xfer_done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ld_cfg = ch_en;
            end
            ST_READ: begin
                bus_req  = 1'b1;
                cap_data = bus_rdy;
            end
            ST_WRITE: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                step_ptrs = bus_rdy;
            end
            ST_ACK: begin
                per_ack = 1'b1;
            end
            ST_DONE: begin
                xfer_done = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              cfg_dir,
    input  logic [ADDR_W-1:0] cfg_per_base,
    input  logic [ADDR_W-1:0] cfg_mem_base,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_per_size,
    input  logic [1:0]        cfg_mem_size,
    input  logic              cfg_per_inc,
    input  logic              cfg_mem_inc,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_rdy,
    output logic              xfer_done,
    output logic [CNT_W-1:0]  remaining
);

    localparam int DW = DATA_W;

    logic              ld_cfg;
    logic              cap_data;
    logic              step_ptrs;
    logic              cnt_zero;
    logic [ADDR_W-1:0] per_cur;
    logic [ADDR_W-1:0] mem_cur;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [1:0]        src_size;
    logic [1:0]        dst_size;
    logic [DW-1:0]     hold_q;

    dma_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .per_req   (per_req),
        .bus_rdy   (bus_rdy),
        .cnt_zero  (cnt_zero),
        .ld_cfg    (ld_cfg),
        .cap_data  (cap_data),
        .step_ptrs (step_ptrs),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .per_ack   (per_ack),
        .xfer_done (xfer_done)
    );

    dma_addr_track #(.ADDR_W(ADDR_W)) u_per_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_cfg),
        .base    (cfg_per_base),
        .advance (step_ptrs),
        .inc_en  (cfg_per_inc),
        .size    (cfg_per_size),
        .cur     (per_cur)
    );

    dma_addr_track #(.ADDR_W(ADDR_W)) u_mem_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_cfg),
        .base    (cfg_mem_base),
        .advance (step_ptrs),
        .inc_en  (cfg_mem_inc),
        .size    (cfg_mem_size),
        .cur     (mem_cur)
    );

    dma_item_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_cfg),
        .init    (cfg_count),
        .dec     (step_ptrs),
        .count   (remaining),
        .is_zero (cnt_zero)
    );

    // Side selection by direction
    always_comb begin
        if (cfg_dir) begin
            src_addr = mem_cur;
            src_size = cfg_mem_size;
            dst_addr = per_cur;
            dst_size = cfg_per_size;
        end else begin
            src_addr = per_cur;
            src_size = cfg_per_size;
            dst_addr = mem_cur;
            dst_size = cfg_mem_size;
        end
    end

    // Captured item, zero-extended from the source size
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cap_data) begin
            hold_q <= bus_rdata & size_mask(src_size);
        end
    end

    assign bus_addr  = bus_we ? dst_addr : src_addr;
    assign bus_size  = bus_we ? dst_size : src_size;
    assign bus_wdata = hold_q & size_mask(dst_size);

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ch_en,
    input logic              per_ack,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_rdy,
    input logic              xfer_done,
    input logic [CNT_W-1:0]  remaining
);

    a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_rdy && ch_en) |=> (bus_req && bus_we));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_ack) |-> (remaining == $past(remaining) - CNT_W'(1)));

    a_r9_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!bus_req && !per_ack));

    a_r10_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (remaining == '0));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rdy && ch_en) |=>
            (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_size)));

    a_r12_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!bus_req && !per_ack && !xfer_done));

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .per_ack   (per_ack),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rdy   (bus_rdy),
    .xfer_done (xfer_done),
    .remaining (remaining)
);

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ch_en = 1'b0;
    logic          cfg_dir = 1'b0;
    logic [AW-1:0] cfg_per_base = '0;
    logic [AW-1:0] cfg_mem_base = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0]    cfg_per_size = 2'b00;
    logic [1:0]    cfg_mem_size = 2'b00;
    logic          cfg_per_inc = 1'b0;
    logic          cfg_mem_inc = 1'b0;
    logic          per_req = 1'b0;
    logic          per_ack;
    logic          bus_req;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_rdy = 1'b0;
    logic          xfer_done;
    logic [CW-1:0] remaining;

    int n_tests = 0;
    int n_fail  = 0;
    bit reported = 1'b0;

    // model state
    logic [AW-1:0] m_pa;
    logic [AW-1:0] m_ma;

    always #10 clk = ~clk;

    dma_xfer_engine #(.ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cfg_dir(cfg_dir),
        .cfg_per_base(cfg_per_base), .cfg_mem_base(cfg_mem_base),
        .cfg_count(cfg_count), .cfg_per_size(cfg_per_size),
        .cfg_mem_size(cfg_mem_size), .cfg_per_inc(cfg_per_inc),
        .cfg_mem_inc(cfg_mem_inc), .per_req(per_req), .per_ack(per_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdy(bus_rdy), .xfer_done(xfer_done), .remaining(remaining)
    );

    function automatic logic [31:0] exp_mask(input logic [1:0] sz);
        if (sz == 2'b00) return 32'h0000_00FF;
        if (sz == 2'b01) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [AW-1:0] exp_step(input logic [1:0] sz, input logic inc);
        if (!inc) return '0;
        if (sz == 2'b00) return AW'(1);
        if (sz == 2'b01) return AW'(2);
        return AW'(4);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL R3 watchdog expired: actual=0x0 expected=0x1");
        report();
        $finish;
    end

    // One bus phase: waits for bus_req, checks fields over random wait states,
    // then completes with bus_rdy.
    task automatic bus_phase(input bit we, input logic [AW-1:0] a,
                             input logic [1:0] sz, input logic [31:0] wd,
                             input string atag, output logic [31:0] rd);
        int waits;
        int g;
        waits = int'($urandom % 3);
        g = 0;
        @(negedge clk);
        bus_rdy = 1'b0;
        while (!bus_req && g < 12) begin
            @(negedge clk);
            g++;
        end
        check(bus_req == 1'b1, "R3", "bus_req", 64'(bus_req), 64'd1);
        for (int k = 0; k < waits; k++) begin
            check(bus_req && bus_addr == a && bus_we == we, "R11", "held access",
                  64'(bus_addr), 64'(a));
            @(negedge clk);
        end
        check(bus_we == we, "R3", "bus_we", 64'(bus_we), 64'(we));
        check(bus_size == sz, "R3", "bus_size", 64'(bus_size), 64'(sz));
        check(bus_addr == a, atag, "bus_addr", 64'(bus_addr), 64'(a));
        if (we) check(bus_wdata == wd, "R7", "bus_wdata", 64'(bus_wdata), 64'(wd));
        rd = $urandom;
        bus_rdata = rd;
        bus_rdy = 1'b1;
    endtask

    task automatic one_item(input bit first, input logic [CW-1:0] exp_rem);
        logic [AW-1:0] sa, da;
        logic [1:0]    ssz, dsz;
        logic          sinc, dinc;
        logic [31:0]   rd, dummy;
        string         rtag, wtag;
        if (cfg_dir) begin
            sa = m_ma; ssz = cfg_mem_size; sinc = cfg_mem_inc;
            da = m_pa; dsz = cfg_per_size; dinc = cfg_per_inc;
        end else begin
            sa = m_pa; ssz = cfg_per_size; sinc = cfg_per_inc;
            da = m_ma; dsz = cfg_mem_size; dinc = cfg_mem_inc;
        end
        rtag = first ? "R2" : (sinc ? "R5" : "R6");
        wtag = first ? "R4" : (dinc ? "R5" : "R6");
        per_req = 1'b1;
        bus_phase(1'b0, sa, ssz, 32'd0, rtag, rd);
        bus_phase(1'b1, da, dsz, rd & exp_mask(ssz) & exp_mask(dsz), wtag, dummy);
        @(negedge clk);
        bus_rdy = 1'b0;
        check(per_ack == 1'b1, "R3", "per_ack after store", 64'(per_ack), 64'd1);
        check(remaining == exp_rem, "R8", "remaining", 64'(remaining), 64'(exp_rem));
        per_req = 1'b0;
        m_pa = m_pa + exp_step(cfg_per_size, cfg_per_inc);
        m_ma = m_ma + exp_step(cfg_mem_size, cfg_mem_inc);
    endtask

    task automatic run_xfer(input int n, input bit dir, input logic [1:0] psz,
                            input logic [1:0] msz, input bit pinc, input bit minc);
        @(negedge clk);
        cfg_dir = dir;
        cfg_per_base = $urandom;
        cfg_mem_base = $urandom;
        cfg_count = CW'(n);
        cfg_per_size = psz;
        cfg_mem_size = msz;
        cfg_per_inc = pinc;
        cfg_mem_inc = minc;
        m_pa = cfg_per_base;
        m_ma = cfg_mem_base;
        ch_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            int gap;
            gap = int'($urandom % 4);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check(bus_req == 1'b0, "R3", "no access without request",
                      64'(bus_req), 64'd0);
            end
            one_item(i == 0, CW'(n - i - 1));
        end
        @(negedge clk);
        check(xfer_done == 1'b1, "R8", "done after last item", 64'(xfer_done), 64'd1);
        per_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(!bus_req && !per_ack && xfer_done, "R9", "request ignored when done",
                  {62'd0, bus_req, per_ack}, 64'd0);
        end
        per_req = 1'b0;
        ch_en = 1'b0;
        @(negedge clk);
        check(xfer_done == 1'b0, "R12", "done cleared on disable", 64'(xfer_done), 64'd0);
    endtask

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd2024);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!bus_req && !per_ack && !xfer_done, "R1", "outputs after reset",
              {61'd0, bus_req, per_ack, xfer_done}, 64'd0);
        check(remaining == '0, "R1", "remaining after reset", 64'(remaining), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: widening and narrowing, fixed peripheral address
        run_xfer(3, 1'b0, 2'b00, 2'b10, 1'b0, 1'b1);
        run_xfer(3, 1'b1, 2'b01, 2'b00, 1'b1, 1'b1);
        run_xfer(1, 1'b0, 2'b11, 2'b01, 1'b1, 1'b0);
        run_xfer(2, 1'b1, 2'b10, 2'b10, 1'b0, 1'b0);

        // zero count
        @(negedge clk);
        cfg_count = '0;
        ch_en = 1'b1;
        per_req = 1'b1;
        @(negedge clk);
        check(bus_req == 1'b0, "R10", "no access on zero count", 64'(bus_req), 64'd0);
        @(negedge clk);
        check(xfer_done == 1'b1 && bus_req == 1'b0, "R10", "done on zero count",
              64'(xfer_done), 64'd1);
        per_req = 1'b0;
        ch_en = 1'b0;
        @(negedge clk);

        // abort in the middle of a read
        cfg_count = CW'(5);
        cfg_dir = 1'b0;
        ch_en = 1'b1;
        per_req = 1'b1;
        bus_rdy = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_req == 1'b1, "R12", "read pending before abort", 64'(bus_req), 64'd1);
        ch_en = 1'b0;
        per_req = 1'b0;
        @(negedge clk);
        check(!bus_req && !per_ack && !xfer_done, "R12", "idle after abort",
              {61'd0, bus_req, per_ack, xfer_done}, 64'd0);

        // random
        for (int t = 0; t < 40; t++) begin
            run_xfer(int'($urandom_range(1, 6)), 1'($urandom), 2'($urandom),
                     2'($urandom), 1'($urandom), 1'($urandom));
        end

        if (seed_sink == 32'hFFFF_FFFF) $display("seed note");
        report();
        $finish;
    end

endmodule